// File: doc/BRIEF.md
# Gate Driver Fault Protection Controller

This block is the digital control core of a single-channel isolated gate driver. It takes two PWM inputs, one non-inverting and one inverting, and merges them into a single gate command. Each input is filtered so that a level change counts only after it has held for a minimum number of clock cycles. The core also takes already-digitised comparator results: desaturation above threshold, input-side supply good, and output-side supply good. From these it produces the gate-on request, a soft turn-off request, an active-low fault flag and a supply-good indication.

At the start of every on-cycle, a blanking window masks the desaturation comparator. A desaturation event outside that window sets a fault latch. The latch drops the gate through the soft turn-off path and pulls the fault flag low. A fixed mute window then starts, and during it both PWM inputs and the active-low clear input are ignored. After a fault clears, after start-up, or after any supply loss, the gate turns on again only on a fresh rising gate command. Every interval is a cycle count taken from a parameter. The defaults suit a 125 MHz clock: a 625-cycle mute (5 µs) and a 25-cycle cap on supply-good low time (200 ns).

Top module: `gate_guard_core`

## Requirements
- R1: With steady inputs, the gate is commanded on only when the filtered non-inverting input is 1 and the filtered inverting input is 0. The inverting input idles at 1 out of reset.
- R2: A level change on either PWM input is ignored unless the new level holds for MIN_PW consecutive clock edges. An input change applied before edge k shows on gateOn after edge k+MIN_PW.
- R3: For the first BLANK cycles of each on-cycle, desatHi is ignored. If desatHi is held from the first cycle of the on period, the fault is taken at edge g+BLANK+1, where g is the edge at which gateOn rose.
- R4: When a fault is taken, the same edge drives gateOn to 0, faultN to 0 and softOff to 1. All three hold until the fault is cleared.
- R5: After the fault edge f, faultClrN has no effect up to and including edge f+MUTE, and the PWM inputs cannot turn the gate on.
- R6: A low faultClrN sampled at or after edge f+MUTE+1 clears the fault at that edge: faultN returns to 1 and softOff to 0.
- R7: After reset, after a fault clears, or after any supply drop, gateOn stays 0 even if the gate command is already high. It turns on only after the filtered command rises again.
- R8: rdyOut goes low at the first edge that samples uvlo2Ok at 0. It returns to 1 after RDY_MAX cycles low, even if the supply is still bad.
- R9: gateOn is 0 after any edge at which uvlo2Ok or rdyOut was 0.
- R10: uvlo1Ok at 0 forces gateOn to 0 after the next edge. It does not set the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inPos | input | 1 | Non-inverting PWM input |
| inNeg | input | 1 | Inverting PWM input |
| desatHi | input | 1 | Desaturation comparator above threshold |
| uvlo1Ok | input | 1 | Input-side supply good |
| uvlo2Ok | input | 1 | Output-side supply good |
| faultClrN | input | 1 | Active-low fault latch clear |
| gateOn | output | 1 | Gate drive on request |
| softOff | output | 1 | Soft turn-off request while a fault is latched |
| faultN | output | 1 | Active-low desaturation fault flag |
| rdyOut | output | 1 | Output-side supply good indication |

## Verification
The hardest state to reach is the exact edge at which the mute window ends. At that edge a clear pulse one cycle early must be ignored, and the same pulse one cycle later must take effect. Seeing this requires a fault taken at a known edge. The stimulus therefore waits for the observed gate rise, holds desatHi for exactly the blanking length, and then counts negative edges from the observed fault to place the clear pulse on each side of the boundary. The supply-good cap is reached the same way, by holding the output-side supply bad past the cap while the gate command stays high.

// File: rtl/gg_pkg.sv
package gg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic muteLoad;
    logic onCycle;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cmd;
    logic cmdRise;
    logic blankDone;
    logic muteActive;
    logic rdyOk;
  } dpStatus_t;
endpackage

// File: rtl/gg_pulse_filter.sv
module gg_pulse_filter #(
  parameter int MIN_PW = 4,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic hold,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(MIN_PW + 1);
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= INIT;
      runCnt <= '0;
    end else if (hold || raw == level) begin
      runCnt <= '0;
    end else if (runCnt == CW'(MIN_PW - 1)) begin
      level  <= raw;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  AST_LEVEL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> ($past(raw) == level)) else $error("filter change without input"); // R2
endmodule

// File: rtl/gg_datapath.sv
module gg_datapath
  import gg_pkg::*;
#(
  parameter int MIN_PW  = 4,
  parameter int BLANK   = 8,
  parameter int MUTE    = 625,
  parameter int RDY_MAX = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inPos,
  input  logic       inNeg,
  input  logic       uvlo2Ok,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int BW = $clog2(BLANK + 1);
  localparam int MW = $clog2(MUTE + 1);
  localparam int RW = $clog2(RDY_MAX + 2);

  logic [1:0]    rawVec;
  logic [1:0]    lvlVec;
  logic          cmd;
  logic          cmdPrev;
  logic [BW-1:0] blankCnt;
  logic [MW-1:0] muteCnt;
  logic [RW-1:0] rdyCnt;
  logic          muteActive;
  logic          rdyOk;

  assign rawVec     = {inNeg, inPos};
  assign muteActive = (muteCnt != '0);

  // index 0: non-inverting (idles low); index 1: inverting (idles high)
  for (genvar i = 0; i < 2; i++) begin : g_filt
    gg_pulse_filter #(.MIN_PW(MIN_PW), .INIT(i == 1)) u_filt (
      .clk  (clk),
      .rstN (rstN),
      .hold (muteActive),
      .raw  (rawVec[i]),
      .level(lvlVec[i])
    );
  end

  assign cmd = lvlVec[0] & ~lvlVec[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdPrev <= 1'b0;
    else       cmdPrev <= cmd;
  end

  // blanking counter restarts whenever the gate is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               blankCnt <= BW'(BLANK);
    else if (!strobe.onCycle) blankCnt <= BW'(BLANK);
    else if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                muteCnt <= '0;
    else if (strobe.muteLoad) muteCnt <= MW'(MUTE);
    else if (muteActive)      muteCnt <= muteCnt - 1'b1;
  end

  // supply-good low time is capped at RDY_MAX cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rdyCnt <= '0;
    else if (uvlo2Ok)                   rdyCnt <= '0;
    else if (rdyCnt != RW'(RDY_MAX + 1)) rdyCnt <= rdyCnt + 1'b1;
  end

  assign rdyOk = !(rdyCnt != '0 && rdyCnt <= RW'(RDY_MAX));

  assign status.cmd        = cmd;
  assign status.cmdRise    = cmd & ~cmdPrev;
  assign status.blankDone  = (blankCnt == '0);
  assign status.muteActive = muteActive;
  assign status.rdyOk      = rdyOk;

  AST_MUTE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.muteLoad |=> muteActive) else $error("mute not started"); // R5
  AST_RDY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyOk) |-> $past(!uvlo2Ok)) else $error("rdy fell without supply loss"); // R8
endmodule

// File: rtl/gg_control.sv
module gg_control
  import gg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       desatHi,
  input  logic       uvlo1Ok,
  input  logic       uvlo2Ok,
  input  logic       faultClrN,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       gateOn,
  output logic       softOff,
  output logic       faultN
);
  logic gateOnQ;
  logic faultLatch;
  logic blocked;
  logic supplyOk;
  logic faultSet;
  logic clrTake;
  logic allowed;
  logic gateNext;

  assign supplyOk = uvlo1Ok & uvlo2Ok & status.rdyOk;
  assign faultSet = gateOnQ & status.blankDone & desatHi & ~faultLatch;
  assign clrTake  = faultLatch & ~faultClrN & ~status.muteActive;
  assign allowed  = supplyOk & ~faultLatch & ~faultSet;
  assign gateNext = status.cmd & allowed & (~blocked | status.cmdRise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultLatch <= 1'b0;
    else if (faultSet) faultLatch <= 1'b1;
    else if (clrTake)  faultLatch <= 1'b0;
  end

  // re-arm only on a fresh rising command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               blocked <= 1'b1;
    else if (!allowed)       blocked <= 1'b1;
    else if (status.cmdRise) blocked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateOnQ <= 1'b0;
    else       gateOnQ <= gateNext;
  end

  assign strobe.muteLoad = faultSet;
  assign strobe.onCycle  = gateOnQ;
  assign gateOn  = gateOnQ;
  assign softOff = faultLatch;
  assign faultN  = ~faultLatch;

  AST_FAULT_KILLS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    faultLatch |-> !gateOnQ) else $error("gate on during fault"); // R4
  AST_FAULT_FROM_ON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatch) |-> $past(gateOnQ && desatHi)) else $error("fault without on-cycle"); // R3
  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOnQ) |=> !faultLatch) else $error("fault inside blank"); // R3
  AST_CLEAR_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatch && status.muteActive) |=> faultLatch) else $error("clear during mute"); // R5
  AST_GATE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    gateOnQ |-> $past(uvlo2Ok && uvlo1Ok)) else $error("gate on with bad supply"); // R9
endmodule

// File: rtl/gate_guard_core.sv
module gate_guard_core
  import gg_pkg::*;
#(
  parameter int MIN_PW  = 4,
  parameter int BLANK   = 8,
  parameter int MUTE    = 625,
  parameter int RDY_MAX = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic inPos,
  input  logic inNeg,
  input  logic desatHi,
  input  logic uvlo1Ok,
  input  logic uvlo2Ok,
  input  logic faultClrN,
  output logic gateOn,
  output logic softOff,
  output logic faultN,
  output logic rdyOut
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  gg_datapath #(.MIN_PW(MIN_PW), .BLANK(BLANK), .MUTE(MUTE), .RDY_MAX(RDY_MAX)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .inPos  (inPos),
    .inNeg  (inNeg),
    .uvlo2Ok(uvlo2Ok),
    .strobe (strobe),
    .status (status)
  );

  gg_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .desatHi  (desatHi),
    .uvlo1Ok  (uvlo1Ok),
    .uvlo2Ok  (uvlo2Ok),
    .faultClrN(faultClrN),
    .status   (status),
    .strobe   (strobe),
    .gateOn   (gateOn),
    .softOff  (softOff),
    .faultN   (faultN)
  );

  assign rdyOut = status.rdyOk;
endmodule

// File: tb/gate_guard_core_tb.sv
module gate_guard_core_tb;
  localparam int MIN_PW  = 4;
  localparam int BLANK   = 8;
  localparam int MUTE    = 625;
  localparam int RDY_MAX = 25;

  // {inPos, inNeg, expected gateOn}
  localparam logic [2:0] VEC [6] = '{3'b101, 3'b110, 3'b010, 3'b000, 3'b101, 3'b000};

  logic clk = 0, rstN = 0;
  logic inPos = 0, inNeg = 1, desatHi = 0, uvlo1Ok = 1, uvlo2Ok = 1, faultClrN = 1;
  logic gateOn, softOff, faultN, rdyOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gate_guard_core #(.MIN_PW(MIN_PW), .BLANK(BLANK), .MUTE(MUTE), .RDY_MAX(RDY_MAX)) u_dut (
    .clk(clk), .rstN(rstN), .inPos(inPos), .inNeg(inNeg), .desatHi(desatHi),
    .uvlo1Ok(uvlo1Ok), .uvlo2Ok(uvlo2Ok), .faultClrN(faultClrN),
    .gateOn(gateOn), .softOff(softOff), .faultN(faultN), .rdyOut(rdyOut)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitGateRise();
    for (int i = 0; i < 50 && gateOn !== 1'b1; i++) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1;
    step(2);
    // reset state
    check("R7 reset gate", gateOn, 1'b0);
    check("R4 reset faultN", faultN, 1'b1);
    check("R4 reset softOff", softOff, 1'b0);
    check("R8 reset rdy", rdyOut, 1'b1);

    // R1 truth table
    foreach (VEC[i]) begin
      inPos = VEC[i][2];
      inNeg = VEC[i][1];
      step(MIN_PW + 3);
      check("R1 table", gateOn, VEC[i][0]);
    end

    // R2 short positive pulse on inPos
    inPos = 1;
    step(MIN_PW - 1);
    inPos = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      check("R2 short pos pulse", gateOn, 1'b0);
    end
    // R2 exact latency
    inPos = 1;
    step(MIN_PW);
    check("R2 latency early", gateOn, 1'b0);
    step(1);
    check("R2 latency on", gateOn, 1'b1);

    // R2 short negative pulse on inNeg
    inNeg = 1;
    step(MIN_PW + 3);
    check("R1 neg high off", gateOn, 1'b0);
    inNeg = 0;
    step(MIN_PW - 1);
    inNeg = 1;
    for (int i = 0; i < 10; i++) begin
      step(1);
      check("R2 short neg pulse", gateOn, 1'b0);
    end
    inNeg = 0;
    step(MIN_PW);
    check("R2 neg latency early", gateOn, 1'b0);
    step(1);
    check("R2 neg latency on", gateOn, 1'b1);

    // R3 desat inside blanking is ignored (fresh on-cycle)
    inPos = 0;
    step(MIN_PW + 3);
    inPos = 1;
    waitGateRise();
    desatHi = 1;
    step(BLANK - 1);
    desatHi = 0;
    step(4);
    check("R3 blank ignores desat", faultN, 1'b1);
    check("R3 gate still on", gateOn, 1'b1);

    // R3/R4 desat held from the start of an on-cycle
    inPos = 0;
    step(MIN_PW + 3);
    inPos = 1;
    waitGateRise();
    desatHi = 1;
    step(BLANK);
    check("R3 no fault at blank end", faultN, 1'b1);
    check("R3 gate on at blank end", gateOn, 1'b1);
    step(1);
    check("R4 faultN low", faultN, 1'b0);
    check("R4 gate low", gateOn, 1'b0);
    check("R4 softOff high", softOff, 1'b1);

    // now at negedge after fault edge f
    desatHi = 0;
    faultClrN = 0;
    inPos = 0;
    step(10);
    faultClrN = 1;
    inPos = 1;
    check("R5 clear ignored in mute", faultN, 1'b0);
    check("R5 gate held low", gateOn, 1'b0);
    step(MUTE - 1 - 10);
    faultClrN = 0;
    step(1);
    check("R5 clear at f+MUTE ignored", faultN, 1'b0);
    step(1);
    check("R6 clear taken", faultN, 1'b1);
    check("R6 softOff released", softOff, 1'b0);
    faultClrN = 1;

    // R7 command still high, no re-enable without new rise
    step(10);
    check("R7 no rearm without rise", gateOn, 1'b0);
    inPos = 0;
    step(MIN_PW + 3);
    inPos = 1;
    step(MIN_PW + 3);
    check("R7 rearm on rise", gateOn, 1'b1);

    // R8/R9 output supply loss
    uvlo2Ok = 0;
    step(1);
    check("R8 rdy low", rdyOut, 1'b0);
    check("R9 gate low with rdy", gateOn, 1'b0);
    step(RDY_MAX - 1);
    check("R8 rdy still low at cap", rdyOut, 1'b0);
    step(1);
    check("R8 rdy released", rdyOut, 1'b1);
    check("R9 gate low supply bad", gateOn, 1'b0);
    uvlo2Ok = 1;
    step(10);
    check("R7 no rearm after supply", gateOn, 1'b0);
    check("R9 no fault flag", faultN, 1'b1);
    inPos = 0;
    step(MIN_PW + 3);
    inPos = 1;
    step(MIN_PW + 3);
    check("R7 rearm after supply", gateOn, 1'b1);

    // R10 input supply loss
    uvlo1Ok = 0;
    step(1);
    check("R10 gate low", gateOn, 1'b0);
    check("R10 faultN high", faultN, 1'b1);
    check("R10 rdy high", rdyOut, 1'b1);
    uvlo1Ok = 1;
    step(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule